// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block collects up to 32 interrupt requests into one interrupt line for a processor. Each request input is fixed at elaboration as edge-captured or level-followed. Captured requests sit in a status word. An enable word masks them, and the masked result is the pending word. A vector word gives the index of the lowest-numbered pending request, and that request has the highest priority. A two-bit master control gates the combined interrupt line.

Software works the block through eight word registers on a simple synchronous write port with a combinational read port. Enable bits cannot be written directly. They change only through a set-bits register and a clear-bits register, so two drivers that each own a few sources need no read-modify-write. Software clears captured requests by writing ones to an acknowledge register. A level request that is still asserted is captured again on the next clock.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the status, enable and master registers read zero, the vector reads all ones and `irq_out` is low.
- R2: Register word addresses are as follows.
  - Status: 0.
  - Pending: 1.
  - Enable: 2.
  - Acknowledge: 3.
  - Set-enable: 4.
  - Clear-enable: 5.
  - Vector: 6.
  - Master: 7.

  Addresses 3, 4 and 5 read zero. Writes to 0, 1 and 6 change nothing.
- R3: A write to address 4 ORs the write data into the enable register. All other enable bits keep their value.
- R4: A write to address 5 clears the enable bits that are one in the write data. All other enable bits keep their value.
- R5: A write to address 3 clears every status bit that is one in the write data. A request captured on the same clock edge wins over the clear.
- R6: For a source whose `SRC_KIND` bit is 1 (edge), the status bit sets on the first clock edge at which the input is high after having been low at the previous edge. The bit stays set after the input falls, until it is acknowledged.
- R7: For a source whose `SRC_KIND` bit is 0 (level), the status bit sets at every clock edge at which the input is high. It is therefore set again after an acknowledge while the input stays high.
- R8: The pending register reads status AND enable. Source n is bit n.
- R9: The vector register reads the index of the lowest-numbered pending bit, zero-extended. It reads all ones when no bit is pending.
- R10: The master register holds write-data bits 1:0 and reads them back in bits 1:0. `irq_out` is high exactly when master bit 0 is set and at least one bit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Interrupt request inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
A register write or a source input takes effect at the first rising edge that samples it. Read data and `irq_out` then follow combinationally from the registers, so every result is due at the next read after that one edge.

The bench drives inputs at the falling edge and steps its reference model at the rising edge. It then sweeps all eight addresses in sub-nanosecond steps before the next falling edge. Every read therefore sees exactly one edge's worth of state change.

// File: rtl/irq_ctrl_pkg.sv
`timescale 1ns/1ps
package irq_ctrl_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      A_STAT   = 3'd0,
      A_PEND   = 3'd1,
      A_EN     = 3'd2,
      A_ACK    = 3'd3,
      A_SETEN  = 3'd4,
      A_CLREN  = 3'd5,
      A_VEC    = 3'd6,
      A_MASTER = 3'd7
   } reg_addr_e;

   localparam int MASTER_W = 2;
endpackage

// File: rtl/irq_src_latch.sv
`timescale 1ns/1ps
module irq_src_latch #(
   parameter int          NUM_SRC  = 32,
   parameter logic [31:0] SRC_KIND = 32'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic [NUM_SRC-1:0] ack_mask,
   output logic [NUM_SRC-1:0] stat
);
   logic [NUM_SRC-1:0] cap;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      if (SRC_KIND[i]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src_in[i];
         end
         assign cap[i] = src_in[i] & ~prev_q;
      end else begin : g_level
         assign cap[i] = src_in[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat[i] <= 1'b0;
         else        stat[i] <= (stat[i] & ~ack_mask[i]) | cap[i];
      end
   end
endmodule

// File: rtl/irq_prio_enc.sv
`timescale 1ns/1ps
module irq_prio_enc #(
   parameter int NUM_SRC = 32,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic [NUM_SRC-1:0] req,
   output logic               found,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      found = |req;
      idx   = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
   import irq_ctrl_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32,
   localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_SRC-1:0]  stat,
   input  logic                vec_found,
   input  logic [IDX_W-1:0]    vec_idx,
   output logic [NUM_SRC-1:0]  en_q,
   output logic [MASTER_W-1:0] mer_q,
   output logic [NUM_SRC-1:0]  ack_mask,
   output logic [NUM_SRC-1:0]  pend
);
   logic [NUM_SRC-1:0] wmask;
   reg_addr_e          sel;

   assign sel      = reg_addr_e'(bus_addr);
   assign wmask    = bus_wdata[NUM_SRC-1:0];
   assign ack_mask = (bus_wr && sel == A_ACK) ? wmask : '0;
   assign pend     = stat & en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         mer_q <= '0;
      end else if (bus_wr) begin
         case (sel)
            A_SETEN:  en_q  <= en_q | wmask;
            A_CLREN:  en_q  <= en_q & ~wmask;
            A_MASTER: mer_q <= bus_wdata[MASTER_W-1:0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         A_STAT:   bus_rdata = DATA_W'(stat);
         A_PEND:   bus_rdata = DATA_W'(pend);
         A_EN:     bus_rdata = DATA_W'(en_q);
         A_VEC:    bus_rdata = vec_found ? DATA_W'(vec_idx) : '1;
         A_MASTER: bus_rdata = DATA_W'(mer_q);
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_ctrl_top.sv
`timescale 1ns/1ps
module irq_ctrl_top
   import irq_ctrl_pkg::*;
#(
   parameter int          NUM_SRC  = 32,
   parameter int          DATA_W   = 32,
   parameter logic [31:0] SRC_KIND = 32'h0000_FFFF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               bus_wr,
   input  logic [2:0]         bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_out
);
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_src
      $error("irq_ctrl_top: NUM_SRC must lie in 1..32");
   end
   if (DATA_W < NUM_SRC || DATA_W < MASTER_W) begin : g_bad_width
      $error("irq_ctrl_top: DATA_W too narrow for sources");
   end

   logic [NUM_SRC-1:0]  stat_q;
   logic [NUM_SRC-1:0]  en_q;
   logic [NUM_SRC-1:0]  ack_mask;
   logic [NUM_SRC-1:0]  pend;
   logic [MASTER_W-1:0] mer_q;
   logic                vec_found;
   logic [IDX_W-1:0]    vec_idx;

   irq_src_latch #(.NUM_SRC(NUM_SRC), .SRC_KIND(SRC_KIND)) u_latch (
      .clk(clk), .rst_n(rst_n), .src_in(src_in),
      .ack_mask(ack_mask), .stat(stat_q)
   );

   irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_enc (
      .req(pend), .found(vec_found), .idx(vec_idx)
   );

   irq_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stat(stat_q),
      .vec_found(vec_found), .vec_idx(vec_idx), .en_q(en_q),
      .mer_q(mer_q), .ack_mask(ack_mask), .pend(pend)
   );

   assign irq_out = mer_q[0] & vec_found;
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk #(
   parameter int          NUM_SRC  = 32,
   parameter int          DATA_W   = 32,
   parameter logic [31:0] SRC_KIND = 32'h0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_in,
   input logic               bus_wr,
   input logic [2:0]         bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               irq_out,
   input logic [NUM_SRC-1:0] stat_q,
   input logic [NUM_SRC-1:0] en_q,
   input logic [1:0]         mer_q
);
   localparam logic [NUM_SRC-1:0] EDG = SRC_KIND[NUM_SRC-1:0];
   localparam logic [NUM_SRC-1:0] LVL = ~EDG;

   logic [NUM_SRC-1:0] wm;
   logic [NUM_SRC-1:0] ack_now;
   assign wm      = bus_wdata[NUM_SRC-1:0];
   assign ack_now = (bus_wr && bus_addr == 3'd3) ? wm : '0;

   // R3
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd4) |=> ((en_q & $past(wm)) == $past(wm)));

   // R4
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 3'd5) |=> ((en_q & $past(wm)) == '0));

   // R7
   lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_in & LVL) != '0) |=> ((stat_q & $past(src_in & LVL)) == $past(src_in & LVL)));

   // R6
   edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & EDG & ~ack_now) != '0) |=>
         ((stat_q & $past(stat_q & EDG & ~ack_now)) == $past(stat_q & EDG & ~ack_now)));

   // R10
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mer_q[0] |-> !irq_out);

   // R9
   vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_q & en_q) == '0 && bus_addr == 3'd6) |-> (bus_rdata == '1));
endmodule

bind irq_ctrl_top irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .SRC_KIND(SRC_KIND)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .irq_out(irq_out), .stat_q(stat_q), .en_q(en_q), .mer_q(mer_q)
);

// File: tb/irq_ctrl_top_bench.sv
`timescale 1ns/1ps
module irq_ctrl_top_bench;
   localparam logic [31:0] KIND = 32'h0000_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] m_stat = '0, m_en = '0, m_prev = '0;
   logic [1:0]  m_mer = '0;

   always #2 clk = ~clk;

   irq_ctrl_top #(.NUM_SRC(32), .DATA_W(32), .SRC_KIND(KIND)) u_irq_ctrl_top (
      .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out)
   );

   function automatic logic [31:0] lowest(input logic [31:0] v);
      for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
      return 32'hFFFF_FFFF;
   endfunction

   function automatic logic [31:0] exp_word(input int a);
      case (a)
         0: return m_stat;
         1: return m_stat & m_en;
         2: return m_en;
         6: return lowest(m_stat & m_en);
         7: return {30'd0, m_mer};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input int a);
      case (a)
         0: return "R5";
         1: return "R8";
         2: return "R3";
         6: return "R9";
         7: return "R10";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // read one register combinationally, no clock edge crossed
   task automatic rd(input int a, output logic [31:0] v);
      bus_addr = 3'(a);
      #0.2;
      v = bus_rdata;
   endtask

   task automatic check_all();
      logic [31:0] v;
      for (int a = 0; a < 8; a++) begin
         rd(a, v);
         chk(tag_of(a), v, exp_word(a));
      end
      chk("R10", {31'd0, irq_out}, {31'd0, m_mer[0] && ((m_stat & m_en) != 0)});
   endtask

   task automatic step(input logic [31:0] s, input logic w, input logic [2:0] a, input logic [31:0] d);
      logic [31:0] ack, cap;
      @(negedge clk);
      src_in = s; bus_wr = w; bus_addr = a; bus_wdata = d;
      ack = (w && a == 3'd3) ? d : 32'd0;
      cap = (s & ~m_prev & KIND) | (s & ~KIND);
      @(posedge clk);
      m_stat = (m_stat & ~ack) | cap;
      m_prev = s;
      if (w && a == 3'd4) m_en = m_en | d;
      if (w && a == 3'd5) m_en = m_en & ~d;
      if (w && a == 3'd7) m_mer = d[1:0];
      #0.05;
      bus_wr = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd4711));
      #9 rst_n = 1'b1;
      @(posedge clk); #0.1;
      // R1 reset state
      rd(0, v); chk("R1", v, 32'd0);
      rd(2, v); chk("R1", v, 32'd0);
      rd(7, v); chk("R1", v, 32'd0);
      rd(6, v); chk("R1", v, 32'hFFFF_FFFF);
      chk("R1", {31'd0, irq_out}, 32'd0);

      // R3 set enable, R10 master on
      step('0, 1, 3'd4, 32'h0010_002C); check_all();
      step('0, 1, 3'd7, 32'h3); check_all();
      // R6 edge source 3 pulses, stays latched after drop
      step(32'h8, 0, 0, 0); check_all();
      step(32'h0, 0, 0, 0);
      rd(0, v); chk("R6", v, 32'h8);
      rd(6, v); chk("R9", v, 32'd3);
      // R9 priority: edges 5 and 2 both latch, lowest wins
      step(32'h24, 0, 0, 0);
      rd(6, v); chk("R9", v, 32'd2);
      // R5 ack clears edge bits for good
      step(32'h24, 1, 3'd3, 32'hFFFF_FFFF);
      rd(0, v); chk("R5", v, 32'd0);
      step(32'h24, 0, 0, 0);
      rd(0, v); chk("R6", v, 32'd0);
      // R7 level source 20 re-latches after ack while high
      step(32'h0010_0000, 0, 0, 0);
      step(32'h0010_0000, 1, 3'd3, 32'h0010_0000);
      rd(0, v); chk("R7", v, 32'h0010_0000);
      // R2 writes to status/pending/vector ignored, write-only reads zero
      step(32'h0010_0000, 1, 3'd1, 32'hFFFF_FFFF);
      step(32'h0010_0000, 1, 3'd6, 32'h0);
      step(32'h0010_0000, 1, 3'd0, 32'h0);
      check_all();
      rd(3, v); chk("R2", v, 32'd0);
      // R8 pending masks status
      step(32'h0010_0000, 1, 3'd5, 32'h0010_0000);
      rd(1, v); chk("R8", v, 32'd0);
      rd(6, v); chk("R9", v, 32'hFFFF_FFFF);
      // R4 clear keeps other bits
      rd(2, v); chk("R4", v, 32'h0000_002C);
      // R10 master off gates output
      step(32'h0000_0000, 1, 3'd4, 32'h0010_0000);
      step(32'h0010_0000, 1, 3'd7, 32'h2);
      chk("R10", {31'd0, irq_out}, 32'd0);
      check_all();

      for (int k = 0; k < 600; k++) begin
         logic [31:0] s, d;
         logic w;
         s = $urandom & $urandom & $urandom;
         d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : ($urandom & $urandom);
         w = $urandom % 2 == 0;
         step(s, w, 3'($urandom % 8), d);
         check_all();
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule